// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of a memory read or write burst. A one-cycle start pulse hands it a starting column, a burst length of four or eight beats, and an ordering kind: wrapped sequential or XOR-interleaved. From the next cycle on it emits one column address per clock, flags each beat as valid, and flags the final beat with a done pulse.

Only the low field of the column changes during a burst. That field is two bits wide for four-beat bursts and three bits wide for eight-beat bursts. All higher column bits repeat the starting value. Length and ordering are captured with the start pulse. A fresh start pulse arriving mid-burst abandons the running burst, and the new burst's first beat appears on the following cycle. Command decoding, CAS latency and the data path are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and while no burst is running, `beat_vld_o` and `last_beat_o` are 0.
- R2: When `start_i` is high at a clock edge, the next cycle shows `beat_vld_o`=1, and `col_o` equals `start_col_i` as sampled at that edge.
- R3: With `order_ilv_i`=0 (sequential), beat b carries low field (start low field + b) modulo the burst length. For example, start 2 with length 4 gives 2,3,0,1.
- R4: With `order_ilv_i`=1 (interleaved), beat b carries low field (start low field XOR b). For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R5: `len8_i`=0 selects 4 beats and `len8_i`=1 selects 8 beats. `beat_vld_o` is high for exactly that many consecutive cycles and then drops, unless another start arrives.
- R6: A 4-beat burst alters only `col_o[1:0]`, and an 8-beat burst alters only `col_o[2:0]`. Every higher bit equals the start column on every beat.
- R7: `last_beat_o` is 1 on the beat whose index equals the burst length minus one, and on no other cycle.
- R8: A start pulse during a running burst aborts it. The next cycle is beat 0 of the new burst.
- R9: `len8_i` and `order_ilv_i` are sampled only with `start_i`. Changing them mid-burst does not alter that burst's addresses or length.
- R10: A start pulse on the last beat chains the next burst with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that loads a new burst |
| start_col_i | input | COL_W | Starting column address |
| len8_i | input | 1 | 0: 4-beat burst, 1: 8-beat burst |
| order_ilv_i | input | 1 | 0: sequential wrap, 1: XOR interleave |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | High on every beat of a burst |
| last_beat_o | output | 1 | High on the final beat |

## Verification
All outputs come from a single register stage. Beat 0 is therefore due one cycle after the edge that samples the start pulse, and beat b is due b cycles after that. The idle cycle, or the next burst's beat 0, follows the last beat by one cycle. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so every comparison falls in the middle of the cycle that the register count predicts. It sweeps every low start value for both lengths and both orderings, and it runs separate abort, chaining and mid-burst input-change cases.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
    localparam int FIELD_W = 3;
    localparam int BEAT_W  = 3;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_lane_calc.sv
module burst_lane_calc
    import burst_col_pkg::*;
(
    input  logic [FIELD_W-1:0] base_i,
    input  logic [BEAT_W-1:0]  idx_i,
    input  burst_order_e       order_i,
    output logic [FIELD_W-1:0] low_o
);
    always_comb begin
        if (order_i == ORD_ILV) begin
            low_o = base_i ^ idx_i;
        end else begin
            low_o = base_i + idx_i;
        end
    end
endmodule

// File: rtl/burst_col_merge.sv
module burst_col_merge #(
    parameter int COL_W   = 10,
    parameter int FIELD_W = 3
) (
    input  logic [COL_W-1:0]   base_i,
    input  logic [FIELD_W-1:0] low_i,
    input  logic [FIELD_W-1:0] mask_i,
    output logic [COL_W-1:0]   col_o
);
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < FIELD_W) begin : g_field
            assign col_o[i] = mask_i[i] ? low_i[i] : base_i[i];
        end else begin : g_upper
            assign col_o[i] = base_i[i];
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             len8_i,
    input  logic             order_ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_beat_o
);
    typedef struct packed {
        logic               active;
        logic [BEAT_W-1:0]  idx;
        logic [COL_W-1:0]   base;
        logic               len8;
        burst_order_e       order;
    } burst_state_t;

    burst_state_t st_d, st_q;

    logic [BEAT_W-1:0]  last_idx;
    logic [FIELD_W-1:0] field_mask;
    logic [FIELD_W-1:0] low_field;
    logic               at_last;

    always_comb begin
        last_idx   = st_q.len8 ? BEAT_W'(7) : BEAT_W'(3);
        field_mask = st_q.len8 ? FIELD_W'(7) : FIELD_W'(3);
        at_last    = st_q.active && (st_q.idx == last_idx);
    end

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
            st_d.base   = start_col_i;
            st_d.len8   = len8_i;
            st_d.order  = burst_order_e'(order_ilv_i);
        end else if (st_q.active) begin
            if (at_last) begin
                st_d.active = 1'b0;
                st_d.idx    = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, idx: '0, base: '0, len8: 1'b0, order: ORD_SEQ};
        end else begin
            st_q <= st_d;
        end
    end

    burst_lane_calc u_lane (
        .base_i  (st_q.base[FIELD_W-1:0]),
        .idx_i   (st_q.idx),
        .order_i (st_q.order),
        .low_o   (low_field)
    );

    burst_col_merge #(
        .COL_W   (COL_W),
        .FIELD_W (FIELD_W)
    ) u_merge (
        .base_i (st_q.base),
        .low_i  (low_field),
        .mask_i (field_mask),
        .col_o  (col_o)
    );

    assign beat_vld_o  = st_q.active;
    assign last_beat_o = at_last;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             last_beat_o
);
    // R2
    start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_vld_o && col_o == $past(start_col_i)));

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && $past(beat_vld_o) && !$past(start_i))
            |-> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

    // R7
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat_o |-> beat_vld_o);

    // R5
    ends_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat_o && !start_i) |=> !beat_vld_o);

    // R1
    idle_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld_o |-> !last_beat_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .last_beat_o (last_beat_o)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             len8_i = 1'b0;
    logic             order_ilv_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_vld_o;
    logic             last_beat_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len8_i      (len8_i),
        .order_ilv_i (order_ilv_i),
        .col_o       (col_o),
        .beat_vld_o  (beat_vld_o),
        .last_beat_o (last_beat_o)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_col(input int col, input bit l8, input bit ilv, input int b);
        int m = l8 ? 7 : 3;
        int low = ilv ? ((col ^ b) & m) : ((col + b) & m);
        return (col & ~m & ((1 << COL_W) - 1)) | low;
    endfunction

    // called at a falling edge; returns at the falling edge showing beat 0
    task automatic launch(input int col, input bit l8, input bit ilv);
        start_i     = 1'b1;
        start_col_i = COL_W'(col);
        len8_i      = l8;
        order_ilv_i = ilv;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // checks nb beats; returns at the falling edge of the last checked beat
    task automatic check_beats(input int col, input bit l8, input bit ilv,
                               input int nb, input bit flip);
        int total = l8 ? 8 : 4;
        for (int b = 0; b < nb; b++) begin
            if (flip) begin
                len8_i      = ~len8_i;
                order_ilv_i = ~order_ilv_i;
            end
            cmp(ilv ? "R4/R6/R9 col" : "R3/R6/R9 col", int'(col_o), exp_col(col, l8, ilv, b));
            cmp("R5 valid", int'(beat_vld_o), 1);
            cmp("R7 last", int'(last_beat_o), (b == total - 1) ? 1 : 0);
            if (b < nb - 1) begin
                @(posedge clk);
                @(negedge clk);
            end
        end
    endtask

    task automatic check_idle(input string tag);
        @(posedge clk);
        @(negedge clk);
        cmp(tag, int'(beat_vld_o), 0);
        cmp("R7 last idle", int'(last_beat_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) cycles++;

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1 valid reset", int'(beat_vld_o), 0);
        cmp("R1 last reset", int'(last_beat_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 valid idle", int'(beat_vld_o), 0);

        // R3 R4 R5 R6: full sweep of low starts, both lengths, both orders
        for (int l = 0; l < 2; l++) begin
            for (int o = 0; o < 2; o++) begin
                for (int s = 0; s < 8; s++) begin
                    int col = (s * 37 + 'h2A8 + l * 64 + o * 128) & ((1 << COL_W) - 1);
                    col = (col & ~7) | s;
                    launch(col, l[0], o[0]);
                    cmp("R2 first beat", int'(col_o), col);
                    check_beats(col, l[0], o[0], l ? 8 : 4, 1'b0);
                    check_idle("R5 valid drops");
                end
            end
        end

        // documented examples
        launch('h102, 1'b0, 1'b0);
        check_beats('h102, 1'b0, 1'b0, 4, 1'b0);
        check_idle("R3 example end");
        launch('h3F5, 1'b1, 1'b1);
        check_beats('h3F5, 1'b1, 1'b1, 8, 1'b0);
        check_idle("R4 example end");

        // R9: flip length/order on every beat of the burst
        launch('h1E6, 1'b1, 1'b0);
        check_beats('h1E6, 1'b1, 1'b0, 8, 1'b1);
        check_idle("R9 length held");
        launch('h0C3, 1'b0, 1'b1);
        check_beats('h0C3, 1'b0, 1'b1, 4, 1'b1);
        check_idle("R9 length held 4");

        // R8: abort after 3 beats of an 8-beat burst
        launch('h251, 1'b1, 1'b0);
        check_beats('h251, 1'b1, 1'b0, 3, 1'b0);
        launch('h08E, 1'b0, 1'b1);
        cmp("R8 abort beat0", int'(col_o), 'h08E);
        check_beats('h08E, 1'b0, 1'b1, 4, 1'b0);
        check_idle("R8 new burst length");

        // R10: chain on the last beat
        launch('h177, 1'b0, 1'b0);
        check_beats('h177, 1'b0, 1'b0, 4, 1'b0);
        launch('h2C1, 1'b1, 1'b1);
        cmp("R10 chained valid", int'(beat_vld_o), 1);
        check_beats('h2C1, 1'b1, 1'b1, 8, 1'b0);
        check_idle("R10 chain end");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule